// File: doc/BRIEF.md
# Fuse Array Manual Read Bridge

This block lets software read a one-time-programmable fuse array one byte at a time by driving the array's read pins by hand. A control word holds the array pins: chip-select and program-enable, both active low, plus strobe, load and a 10-bit byte address. Every bit of the control word goes straight to the pins of the array. The byte that the array presents comes back through a data word.

A read takes several register writes. Software first writes load with program-enable. It then sets the address and raises strobe, reads the data word, and drops strobe again. To put the array into standby, software writes chip-select together with program-enable and leaves load clear.

The register port is a plain valid/ready port with a 4-bit byte address. It is always ready, and it answers each read one cycle after the read is accepted. The array is modelled as a fixed 1024-byte read-only store whose contents are computed by a formula.

Top module: `fuse_pin_bridge`

## Requirements
- R1: After reset the control word reads 0x9: chip-select high (inactive), program-enable high (inactive), strobe low, load low and address zero. No response is pending.
- R2: A write to word 0 (address 0x0) stores four control bits and the address. Bit 0 is chip-select (active low), bit 1 is strobe, bit 2 is load, bit 3 is program-enable (active low) and bits 15:6 are the byte address. These values appear on the pins in the cycle after the write. All other bits read back as zero.
- R3: `reqReady` is always high. Each accepted read raises `rspValid` for exactly one cycle, in the cycle after it is accepted. A write produces no response.
- R4: A read of word 1 (address 0x4) returns the addressed fuse byte in bits 7:0 when chip-select is low, strobe is high and load is high. Bits 31:8 read zero.
- R5: The data word reads zero when strobe is low, when chip-select is high or when load is low.
- R6: Reads of words 2 and 3 (addresses 0x8 and 0xC) return zero. Writes to words 1, 2 and 3 leave the control word and the pins unchanged.
- R7: The fuse byte at address a equals ((29*a) mod 256) XOR (a div 4), keeping the low 8 bits.
- R8: A read reflects the control word as it stands when the read is accepted, including a write accepted in the cycle just before.
- R9: Address bits 1:0 are ignored. Only bits 3:2 select the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Register request present |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 4 | Byte address of the register |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Read response data |
| fuseCsn | output | 1 | Array chip-select, active low |
| fuseStrobe | output | 1 | Array strobe |
| fuseLoad | output | 1 | Array load (read mode) |
| fusePgmN | output | 1 | Array program-enable, active low |
| fuseAddr | output | 10 | Array byte address |

## Verification
Two things can happen in the same cycle: a control write changes the pins, and the response to the read accepted just before it comes out. The reverse order matters as well. A write sets up the address and strobe, and the next request, issued with no gap, reads the data word. The bench sweeps every one of the 1024 addresses in that order. It expects each byte from the formula, so a read that saw stale pins reads the wrong byte or zero. Reads of the data word with strobe low, chip-select high or load low must return zero.

// File: rtl/fuse_bridge_pkg.sv
package fuse_bridge_pkg;
  localparam int FUSE_AW = 10;

  // Decoded bus operations, control -> datapath
  typedef struct packed {
    logic ctrlWr;
    logic rdAny;
    logic rdCtrl;
    logic rdData;
  } busOps_t;

  typedef struct packed {
    logic               csn;
    logic               strobe;
    logic               load;
    logic               pgmn;
    logic [FUSE_AW-1:0] addr;
  } fusePins_t;

  function automatic logic [7:0] fuseContent(input logic [FUSE_AW-1:0] a);
    logic [FUSE_AW+4:0] prod;
    logic [FUSE_AW-1:0] quarter;
    prod    = (FUSE_AW+5)'(a) * (FUSE_AW+5)'(29);
    quarter = a >> 2;
    return prod[7:0] ^ quarter[7:0];
  endfunction
endpackage

// File: rtl/fuse_bridge_ctrl.sv
module fuse_bridge_ctrl
  import fuse_bridge_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [REG_AW-1:0] reqAddr,
  output logic              reqReady,
  output busOps_t           ops
);
  localparam int WORD_W = REG_AW - 2;
  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(0);
  localparam logic [WORD_W-1:0] DATA_WORD = WORD_W'(1);

  logic [WORD_W-1:0] word;
  logic              unusedByteLanes;

  assign word            = reqAddr[REG_AW-1:2];
  assign unusedByteLanes = ^reqAddr[1:0];
  assign reqReady        = 1'b1;

  always_comb begin
    ops        = '0;
    ops.ctrlWr = reqValid && reqWrite && (word == CTRL_WORD);
    ops.rdAny  = reqValid && !reqWrite;
    ops.rdCtrl = ops.rdAny && (word == CTRL_WORD);
    ops.rdData = ops.rdAny && (word == DATA_WORD);
  end
endmodule

// File: rtl/fuse_bridge_dp.sv
module fuse_bridge_dp
  import fuse_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  busOps_t           ops,
  input  logic [DATA_W-1:0] wdata,
  input  logic [7:0]        fuseDout,
  output fusePins_t         pins,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int CSN_BIT  = 0;
  localparam int STB_BIT  = 1;
  localparam int LOAD_BIT = 2;
  localparam int PGM_BIT  = 3;
  localparam int ADDR_LSB = 6;
  localparam int ADDR_MSB = ADDR_LSB + FUSE_AW - 1;

  fusePins_t         pinsQ;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] dataWord;
  logic              unusedWdata;

  assign unusedWdata = ^{wdata[DATA_W-1:ADDR_MSB+1], wdata[ADDR_LSB-1:PGM_BIT+1]};
  assign pins        = pinsQ;

  always_comb begin
    ctrlWord                        = '0;
    ctrlWord[CSN_BIT]               = pinsQ.csn;
    ctrlWord[STB_BIT]               = pinsQ.strobe;
    ctrlWord[LOAD_BIT]              = pinsQ.load;
    ctrlWord[PGM_BIT]               = pinsQ.pgmn;
    ctrlWord[ADDR_MSB:ADDR_LSB]     = pinsQ.addr;
    dataWord                        = '0;
    dataWord[7:0]                   = fuseDout;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pinsQ      <= '0;
      pinsQ.csn  <= 1'b1;
      pinsQ.pgmn <= 1'b1;
    end else if (ops.ctrlWr) begin
      pinsQ.csn    <= wdata[CSN_BIT];
      pinsQ.strobe <= wdata[STB_BIT];
      pinsQ.load   <= wdata[LOAD_BIT];
      pinsQ.pgmn   <= wdata[PGM_BIT];
      pinsQ.addr   <= wdata[ADDR_MSB:ADDR_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= ops.rdAny;
      if (ops.rdCtrl)      rspData <= ctrlWord;
      else if (ops.rdData) rspData <= dataWord;
      else                 rspData <= '0;
    end
  end

  // R3
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(ops.rdAny));

  // R3
  no_rsp_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ops.ctrlWr) |=> !rspValid);

  // R5
  gated_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ops.rdData && (!pinsQ.strobe || pinsQ.csn || !pinsQ.load)) |=> (rspData == '0));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ops.ctrlWr |=> $stable(pinsQ));

  // R2
  addr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ops.ctrlWr |=> (pins.addr == $past(wdata[ADDR_MSB:ADDR_LSB])));
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model
  import fuse_bridge_pkg::*;
(
  input  fusePins_t  pins,
  output logic [7:0] dout
);
  // Read-only store: byte presented only while selected, in load mode, with strobe high
  always_comb begin
    if (!pins.csn && pins.load && pins.strobe) dout = fuseContent(pins.addr);
    else                                        dout = 8'h00;
  end
endmodule

// File: rtl/fuse_pin_bridge.sv
module fuse_pin_bridge
  import fuse_bridge_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [REG_AW-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               fuseCsn,
  output logic               fuseStrobe,
  output logic               fuseLoad,
  output logic               fusePgmN,
  output logic [FUSE_AW-1:0] fuseAddr
);
  busOps_t   ops;
  fusePins_t pins;
  logic [7:0] arrayDout;

  fuse_bridge_ctrl #(.REG_AW(REG_AW)) ctrl_i (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqReady(reqReady), .ops(ops)
  );

  fuse_bridge_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .ops(ops), .wdata(reqWdata), .fuseDout(arrayDout),
    .pins(pins), .rspValid(rspValid), .rspData(rspData)
  );

  fuse_array_model array_i (.pins(pins), .dout(arrayDout));

  assign fuseCsn    = pins.csn;
  assign fuseStrobe = pins.strobe;
  assign fuseLoad   = pins.load;
  assign fusePgmN   = pins.pgmn;
  assign fuseAddr   = pins.addr;
endmodule

// File: tb/fuse_pin_bridge_tb_top.sv
module fuse_pin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqAddr = 4'h0;
  logic [31:0] reqWdata = 32'h0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        fuseCsn, fuseStrobe, fuseLoad, fusePgmN;
  logic [9:0]  fuseAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fuse_pin_bridge dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .fuseCsn(fuseCsn),
    .fuseStrobe(fuseStrobe), .fuseLoad(fuseLoad), .fusePgmN(fusePgmN),
    .fuseAddr(fuseAddr)
  );

  function automatic logic [31:0] expByte(input int a);
    return 32'(((a * 29) % 256) ^ ((a / 4) % 256));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive at negedge, accepted at next posedge, sample at the following negedge
  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [31:0] d, output logic v);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    d = rspData; v = rspValid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {28'h0, fusePgmN, fuseLoad, fuseStrobe, fuseCsn}, 32'h9);
    check("R1 addr", {22'h0, fuseAddr}, 32'h0);
    check("R1 rspValid", {31'h0, rspValid}, 32'h0);
    doRead(4'h0, rd, v);
    check("R1 ctrl readback", rd, 32'h9);
    check("R3 read response", {31'h0, v}, 32'h1);
    @(negedge clk);
    check("R3 single pulse", {31'h0, rspValid}, 32'h0);
    check("R3 ready", {31'h0, reqReady}, 32'h1);

    // R2 field storage and masking
    doWrite(4'h0, 32'hFFFF_FFFF);
    check("R3 no response to write", {31'h0, rspValid}, 32'h0);
    check("R2 pins", {fuseAddr, fusePgmN, fuseLoad, fuseStrobe, fuseCsn}, {10'h3FF, 4'hF});
    doRead(4'h0, rd, v);
    check("R2 readback mask", rd, 32'h0000_FFCF);

    // R4 R7 R8: sweep every address, write then read back to back
    doWrite(4'h0, 32'hC);
    for (int a = 0; a < 1024; a++) begin
      doWrite(4'h0, 32'h6 | (32'(a) << 6)); // csn low, strobe, load, pgmn low
      doRead(4'h4, rd, v);
      check("R7 R8 R4 fuse byte", rd, expByte(a));
    end

    // R5 gating on each pin
    for (int a = 0; a < 1024; a += 97) begin
      doWrite(4'h0, 32'hC | (32'(a) << 6)); // strobe low
      doRead(4'h4, rd, v);
      check("R5 strobe low", rd, 32'h0);
      doWrite(4'h0, 32'h7 | (32'(a) << 6)); // csn high
      doRead(4'h4, rd, v);
      check("R5 csn high", rd, 32'h0);
      doWrite(4'h0, 32'h2 | (32'(a) << 6)); // load low
      doRead(4'h4, rd, v);
      check("R5 load low", rd, 32'h0);
    end
    // standby value
    doWrite(4'h0, 32'h9);
    doRead(4'h4, rd, v);
    check("R5 standby zero", rd, 32'h0);

    // R6 unmapped and ignored writes
    doWrite(4'h0, 32'h6 | (32'd77 << 6));
    doRead(4'h8, rd, v);
    check("R6 word2 zero", rd, 32'h0);
    doRead(4'hC, rd, v);
    check("R6 word3 zero", rd, 32'h0);
    doWrite(4'h8, 32'hFFFF_FFFF);
    doWrite(4'hC, 32'h0);
    doWrite(4'h4, 32'h9);
    check("R6 pins held", {fuseAddr, fusePgmN, fuseLoad, fuseStrobe, fuseCsn}, {10'd77, 4'h6});
    doRead(4'h0, rd, v);
    check("R6 ctrl held", rd, 32'h6 | (32'd77 << 6));

    // R9 low address bits ignored
    doRead(4'h5, rd, v);
    check("R9 data via 0x5", rd, expByte(77));
    doRead(4'h3, rd, v);
    check("R9 ctrl via 0x3", rd, 32'h6 | (32'd77 << 6));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule